// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Flag Timing

This block buffers 36-bit words between a writer and a reader that run on separate free-running clocks. The clocks may be unrelated or may be the same clock. The memory depth is a power of two set by a parameter, with a default of 2,048 words. Pointers pass between the two domains in Gray code, through two-stage synchronizers.

A master reset selects one of two read timings, and the choice holds until the next master reset. In standard timing, the read flag means "empty" and the write flag means "full". A read returns its word on the cycle after the request. In fall-through timing, the oldest word is placed on the read bus without being asked for. The read flag then means "a word is valid here" and the write flag means "room for a write". Two threshold flags warn of a nearly empty or nearly full store. Their offsets come from one of five preset depths, or from a load made after the master reset: either a serial bit stream or two words on the write bus.

A partial reset empties the store and keeps the timing mode and offsets. A retransmit pulse moves the reader back to the first word written after the last reset.

Top module: `flexflag_fifo`

## Requirements
- R1: After a master reset in standard timing: rflag_o=1, wflag_o=0, aempty_o=1 and afull_o=0. After a master reset in fall-through timing: rflag_o=0 and wflag_o=1.
- R2: In standard timing, words come back in write order. A read request (rd_en_i=1) in a cycle where rflag_o=0 loads the next word onto rdata_o at that rclk_i edge. rdata_o holds its value when rd_en_i=0.
- R3: In fall-through timing, rflag_o=1 means rdata_o holds the oldest unread word, and no request is needed for it to appear. rd_en_i=1 while rflag_o=1 consumes that word. rdata_o and rflag_o hold while rd_en_i=0.
- R4: ofs_sel_i is sampled while rst_ni is low and for two wclk_i edges after its release. Codes 0 to 4 set both offsets to 8, 16, 64, 256 and 1,024 words respectively. The timing mode is taken from fwft_sel_i in the same window (1 = fall-through).
- R5: aempty_o=1 when the number of words held in memory is at or below the empty offset. afull_o=1 when the free space (DEPTH minus the words held) is at or below the full offset. In fall-through timing, a word already presented on rdata_o no longer counts as held.
- R6: ofs_sel_i=5 selects a serial load. On each wclk_i edge with ser_en_i=1, one bit is taken from ser_di_i, for 2*(AW+1) bits in total: first the empty offset, then the full offset, each most significant bit first. Writes are ignored until the load is complete.
- R7: ofs_sel_i=6 or 7 selects a parallel load. The first two write requests after master reset load the empty offset and then the full offset from wdata_i[AW:0]. Neither of these words is stored.
- R8: A low pulse on part_rst_ni empties the store and keeps the timing mode and both offsets.
- R9: A write while full, or a read while empty, changes no pointer and no stored word.
- R10: A high pulse on rt_i rewinds the read side to the first word written after the last reset, so those words are delivered again in order. This holds as long as no more than DEPTH words were written after that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Master reset, active low. Clears data and reloads the configuration. |
| part_rst_ni | input | 1 | Partial reset, active low. Clears data only. |
| fwft_sel_i | input | 1 | Timing select, sampled at master reset (1 = fall-through) |
| ofs_sel_i | input | 3 | Offset source/preset select, sampled at master reset |
| ser_en_i | input | 1 | Serial offset load enable (wclk_i domain) |
| ser_di_i | input | 1 | Serial offset load data |
| wclk_i | input | 1 | Write clock |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | DW | Write data; also carries parallel offset words |
| wflag_o | output | 1 | Full (standard) or input-ready (fall-through) |
| afull_o | output | 1 | Almost-full threshold flag |
| rclk_i | input | 1 | Read clock |
| rd_en_i | input | 1 | Read request |
| rt_i | input | 1 | Retransmit pulse (rclk_i domain) |
| rdata_o | output | DW | Read data |
| rflag_o | output | 1 | Empty (standard) or output-ready (fall-through) |
| aempty_o | output | 1 | Almost-empty threshold flag |

## Verification
Several corner cases are driven directly. The bench fills the store to the last entry and then writes once more. A design that let that write through would overwrite the oldest word, and the drain would return it wrong. The bench reads while empty and then writes a single word. A reader pointer that had slipped forward would return the wrong data, or none. Both threshold flags are checked one word either side of their offsets. This covers preset, serial and parallel offsets, and the fall-through case where the presented word leaves the count. An off-by-one compare or a miscounted output register shows up as a wrong flag. The bench also checks that the offset words from a parallel load and a write made before a serial load never appear in the read stream. It checks that a partial reset keeps the 16-word threshold, and that retransmit replays exactly the words written since that reset.

// File: rtl/flexflag_fifo_pkg.sv
`timescale 1ns/1ps
package flexflag_fifo_pkg;

  typedef enum logic [1:0] {
    SRC_PRESET   = 2'd0,
    SRC_SERIAL   = 2'd1,
    SRC_PARALLEL = 2'd2
  } ofs_src_e;

  function automatic ofs_src_e src_of(input logic [2:0] sel);
    if (sel <= 3'd4)      return SRC_PRESET;
    else if (sel == 3'd5) return SRC_SERIAL;
    else                  return SRC_PARALLEL;
  endfunction

  function automatic int unsigned preset_words(input logic [2:0] sel);
    case (sel)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 64;
      3'd3:    return 256;
      default: return 1024;
    endcase
  endfunction

endpackage

// File: rtl/flexflag_fifo_sync.sv
`timescale 1ns/1ps
module flexflag_fifo_sync #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/flexflag_fifo_cfg.sv
`timescale 1ns/1ps
module flexflag_fifo_cfg
  import flexflag_fifo_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_sel_i,
  input  logic [2:0]    ofs_sel_i,
  input  logic          ser_en_i,
  input  logic          ser_di_i,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wdata_lo_i,
  output logic          fwft_o,
  output logic          ready_o,
  output logic [CW-1:0] ae_off_o,
  output logic [CW-1:0] af_off_o
);
  localparam int NB   = 2 * CW;
  localparam int CNTW = $clog2(NB + 1);

  logic [1:0]      mrst_q;
  logic            mrst_done;
  ofs_src_e        src_q;
  logic            fwft_q, ready_q;
  logic [NB-2:0]   sr_q;
  logic [CNTW-1:0] cnt_q;
  logic [CW-1:0]   ae_q, af_q;

  // reset synchronizer: configuration is captured on wclk while it is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mrst_q <= 2'b00;
    else         mrst_q <= {mrst_q[0], 1'b1};
  end
  assign mrst_done = mrst_q[1];

  always_ff @(posedge clk_i) begin
    if (!mrst_done) begin
      fwft_q <= fwft_sel_i;
      src_q  <= src_of(ofs_sel_i);
      cnt_q  <= '0;
      sr_q   <= '0;
      if (src_of(ofs_sel_i) == SRC_PRESET) begin
        ae_q    <= CW'(preset_words(ofs_sel_i));
        af_q    <= CW'(preset_words(ofs_sel_i));
        ready_q <= 1'b1;
      end else begin
        ae_q    <= '0;
        af_q    <= '0;
        ready_q <= 1'b0;
      end
    end else if (!ready_q) begin
      if (src_q == SRC_SERIAL && ser_en_i) begin
        sr_q  <= {sr_q[NB-3:0], ser_di_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNTW'(NB - 1)) begin
          ae_q    <= sr_q[NB-2:CW-1];
          af_q    <= {sr_q[CW-2:0], ser_di_i};
          ready_q <= 1'b1;
        end
      end else if (src_q == SRC_PARALLEL && wr_en_i) begin
        if (cnt_q == '0) begin
          ae_q  <= wdata_lo_i;
          cnt_q <= CNTW'(1);
        end else begin
          af_q    <= wdata_lo_i;
          ready_q <= 1'b1;
        end
      end
    end
  end

  assign fwft_o   = fwft_q;
  assign ready_o  = ready_q;
  assign ae_off_o = ae_q;
  assign af_off_o = af_q;
endmodule

// File: rtl/flexflag_fifo_wr.sv
`timescale 1ns/1ps
module flexflag_fifo_wr #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          cfg_ready_i,
  input  logic          fwft_i,
  input  logic [AW:0]   af_off_i,
  input  logic [AW:0]   rgray_s_i,
  output logic          wr_ok_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          wflag_o,
  output logic          afull_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wbin_q, wgray_q, wbin_nxt, used, room;
  logic        full;

  assign full     = (wgray_q == {~rgray_s_i[AW:AW-1], rgray_s_i[AW-2:0]});
  assign wr_ok_o  = wr_en_i && cfg_ready_i && !full;
  assign wbin_nxt = wbin_q + PW'(wr_ok_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  assign used    = wbin_q - g2b(rgray_s_i);
  assign room    = PW'(DEPTH) - used;
  assign afull_o = (room <= af_off_i);
  assign wflag_o = fwft_i ? (!full && cfg_ready_i) : full;
  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
endmodule

// File: rtl/flexflag_fifo_rd.sv
`timescale 1ns/1ps
module flexflag_fifo_rd #(
  parameter int AW = 11,
  parameter int DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          rt_i,
  input  logic          fwft_i,
  input  logic [AW:0]   ae_off_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [DW-1:0] mem_q_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          rflag_o,
  output logic          aempty_o
);
  localparam int PW = AW + 1;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0]   rbin_q, rgray_q, rbin_nxt, held;
  logic [DW-1:0] rdata_q;
  logic          ov_q, ram_empty, pop;

  assign ram_empty = (rgray_q == wgray_s_i);
  // fall-through prefetches whenever the output register is free or being drained
  assign pop      = fwft_i ? (!ram_empty && (!ov_q || rd_en_i))
                           : (rd_en_i && !ram_empty);
  assign rbin_nxt = rbin_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      rdata_q <= '0;
      ov_q    <= 1'b0;
    end else if (rt_i) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      ov_q    <= 1'b0;
    end else begin
      if (pop) begin
        rbin_q  <= rbin_nxt;
        rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
        rdata_q <= mem_q_i;
      end
      if (pop)          ov_q <= 1'b1;
      else if (rd_en_i) ov_q <= 1'b0;
    end
  end

  assign held     = g2b(wgray_s_i) - rbin_q;
  assign aempty_o = (held <= ae_off_i);
  assign rflag_o  = fwft_i ? ov_q : ram_empty;
  assign raddr_o  = rbin_q[AW-1:0];
  assign rgray_o  = rgray_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/flexflag_fifo.sv
`timescale 1ns/1ps
module flexflag_fifo #(
  parameter int DW = 36,
  parameter int AW = 11
) (
  input  logic          rst_ni,
  input  logic          part_rst_ni,
  input  logic          fwft_sel_i,
  input  logic [2:0]    ofs_sel_i,
  input  logic          ser_en_i,
  input  logic          ser_di_i,
  input  logic          wclk_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wflag_o,
  output logic          afull_o,
  input  logic          rclk_i,
  input  logic          rd_en_i,
  input  logic          rt_i,
  output logic [DW-1:0] rdata_o,
  output logic          rflag_o,
  output logic          aempty_o
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          arst_n;
  logic          cfg_fwft, cfg_ready, wr_ok;
  logic [CW-1:0] ae_off, af_off;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_q;
  logic [DW-1:0] mem [DEPTH];

  assign arst_n = rst_ni & part_rst_ni;

  flexflag_fifo_cfg #(.CW(CW)) u_cfg (
    .clk_i      (wclk_i),
    .rst_ni     (rst_ni),
    .fwft_sel_i (fwft_sel_i),
    .ofs_sel_i  (ofs_sel_i),
    .ser_en_i   (ser_en_i),
    .ser_di_i   (ser_di_i),
    .wr_en_i    (wr_en_i),
    .wdata_lo_i (wdata_i[CW-1:0]),
    .fwft_o     (cfg_fwft),
    .ready_o    (cfg_ready),
    .ae_off_o   (ae_off),
    .af_off_o   (af_off)
  );

  flexflag_fifo_sync #(.W(AW + 1)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (arst_n),
    .d_i    (rgray),
    .q_o    (rgray_s)
  );

  flexflag_fifo_sync #(.W(AW + 1)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (arst_n),
    .d_i    (wgray),
    .q_o    (wgray_s)
  );

  flexflag_fifo_wr #(.AW(AW)) u_wr (
    .clk_i       (wclk_i),
    .rst_ni      (arst_n),
    .wr_en_i     (wr_en_i),
    .cfg_ready_i (cfg_ready),
    .fwft_i      (cfg_fwft),
    .af_off_i    (af_off),
    .rgray_s_i   (rgray_s),
    .wr_ok_o     (wr_ok),
    .waddr_o     (waddr),
    .wgray_o     (wgray),
    .wflag_o     (wflag_o),
    .afull_o     (afull_o)
  );

  always_ff @(posedge wclk_i) begin
    if (wr_ok) mem[waddr] <= wdata_i;
  end
  assign mem_q = mem[raddr];

  flexflag_fifo_rd #(.AW(AW), .DW(DW)) u_rd (
    .clk_i     (rclk_i),
    .rst_ni    (arst_n),
    .rd_en_i   (rd_en_i),
    .rt_i      (rt_i),
    .fwft_i    (cfg_fwft),
    .ae_off_i  (ae_off),
    .wgray_s_i (wgray_s),
    .mem_q_i   (mem_q),
    .raddr_o   (raddr),
    .rgray_o   (rgray),
    .rdata_o   (rdata_o),
    .rflag_o   (rflag_o),
    .aempty_o  (aempty_o)
  );
endmodule

// File: rtl/flexflag_fifo_chk.sv
`timescale 1ns/1ps
module flexflag_fifo_chk #(
  parameter int AW = 11,
  parameter int DW = 36
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          arst_ni,
  input logic          fwft_i,
  input logic          wflag_i,
  input logic          rflag_i,
  input logic          rd_en_i,
  input logic          rt_i,
  input logic [DW-1:0] rdata_i,
  input logic [AW:0]   wgray_i,
  input logic [AW:0]   rgray_i
);
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wclk_i) disable iff (!arst_ni)
    (fwft_i ? !wflag_i : wflag_i) |=> $stable(wgray_i)); // R9

  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    (!fwft_i && rflag_i && !rt_i) |=> $stable(rgray_i)); // R9

  AST_WPTR_ONE_BIT: assert property (@(posedge wclk_i) disable iff (!arst_ni)
    $countones(wgray_i ^ $past(wgray_i)) <= 1); // R2

  AST_STD_DATA_HOLD: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    (!fwft_i && !rd_en_i) |=> $stable(rdata_i)); // R2

  AST_FWFT_HOLD: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    (fwft_i && rflag_i && !rd_en_i && !rt_i) |=> (rflag_i && $stable(rdata_i))); // R3

  AST_RETX_REWIND: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    rt_i |=> (rgray_i == '0)); // R10
endmodule

bind flexflag_fifo flexflag_fifo_chk #(.AW(AW), .DW(DW)) u_chk (
  .wclk_i  (wclk_i),
  .rclk_i  (rclk_i),
  .arst_ni (arst_n),
  .fwft_i  (cfg_fwft),
  .wflag_i (wflag_o),
  .rflag_i (rflag_o),
  .rd_en_i (rd_en_i),
  .rt_i    (rt_i),
  .rdata_i (rdata_o),
  .wgray_i (wgray),
  .rgray_i (rgray)
);

// File: tb/flexflag_fifo_bench.sv
`timescale 1ns/1ps
module flexflag_fifo_bench;
  localparam int DW = 36;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic rst_ni, part_rst_ni, fwft_sel, ser_en, ser_di;
  logic [2:0] ofs_sel;
  logic wclk, rclk, wr_en, rd_en, rt;
  logic [DW-1:0] wdata, rdata;
  logic wflag, afull, rflag, aempty;

  int checks = 0;
  int errors = 0;
  bit mode_fwft = 0;
  logic [DW-1:0] exp_q[$];

  flexflag_fifo #(.DW(DW), .AW(AW)) u_flexflag_fifo (
    .rst_ni(rst_ni), .part_rst_ni(part_rst_ni), .fwft_sel_i(fwft_sel),
    .ofs_sel_i(ofs_sel), .ser_en_i(ser_en), .ser_di_i(ser_di),
    .wclk_i(wclk), .wr_en_i(wr_en), .wdata_i(wdata), .wflag_o(wflag), .afull_o(afull),
    .rclk_i(rclk), .rd_en_i(rd_en), .rt_i(rt), .rdata_o(rdata), .rflag_o(rflag),
    .aempty_o(aempty)
  );

  initial begin wclk = 0; forever #5 wclk = ~wclk; end
  initial begin rclk = 0; #3; forever #5 rclk = ~rclk; end

  function automatic logic [DW-1:0] pat(input int i);
    return (DW'(i) * DW'(40503)) ^ DW'(36'h5A5A5A5A5);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: compares delivered words against the scoreboard queue
  initial begin
    bit pend = 0;
    forever begin
      @(negedge rclk);
      if (mode_fwft ? (rd_en && rflag) : pend) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL %s actual=%0h expected=none", mode_fwft ? "R3" : "R2", rdata);
        end else begin
          chk(mode_fwft ? "R3 read data" : "R2 read data", 64'(rdata), 64'(exp_q.pop_front()));
        end
      end
      pend = !mode_fwft && rd_en && !rflag;
    end
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic put(input logic [DW-1:0] d, input bit push);
    @(posedge wclk); #2;
    wr_en = 1; wdata = d;
    if (push) exp_q.push_back(d);
    @(posedge wclk); #2;
    wr_en = 0;
  endtask

  task automatic get();
    @(posedge rclk); #2; rd_en = 1;
    @(posedge rclk); #2; rd_en = 0;
  endtask

  task automatic settle();
    repeat (10) @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic drain();
    settle();
    while (mode_fwft ? rflag : !rflag) get();
    settle();
  endtask

  task automatic mrst(input bit f, input logic [2:0] sel);
    @(posedge wclk); #2;
    rst_ni = 0; fwft_sel = f; ofs_sel = sel; mode_fwft = f;
    exp_q.delete();
    repeat (4) @(posedge wclk); #2;
    rst_ni = 1;
    settle();
  endtask

  task automatic shift_ofs(input logic [AW:0] ae, input logic [AW:0] af);
    logic [2*AW+1:0] v;
    v = {ae, af};
    for (int i = 2*AW+1; i >= 0; i--) begin
      @(posedge wclk); #2; ser_en = 1; ser_di = v[i];
    end
    @(posedge wclk); #2; ser_en = 0;
  endtask

  initial begin
    rst_ni = 0; part_rst_ni = 1; fwft_sel = 0; ofs_sel = 0; ser_en = 0; ser_di = 0;
    wr_en = 0; rd_en = 0; rt = 0; wdata = '0;

    // standard timing, preset 8
    mrst(0, 3'd0);
    chk("R1 rflag", 64'(rflag), 64'd1);
    chk("R1 wflag", 64'(wflag), 64'd0);
    chk("R1 aempty", 64'(aempty), 64'd1);
    chk("R1 afull", 64'(afull), 64'd0);

    get(); // read while empty
    put(pat(1), 1);
    drain();
    chk("R9 empty read ignored", 64'(exp_q.size()), 64'd0);

    for (int i = 0; i < DEPTH - 9; i++) put(pat(100 + i), 1);
    settle();
    chk("R5 afull free=9", 64'(afull), 64'd0);
    chk("R5 aempty high count", 64'(aempty), 64'd0);
    put(pat(100 + DEPTH - 9), 1);
    settle();
    chk("R4 afull free=8", 64'(afull), 64'd1);
    for (int i = DEPTH - 8; i < DEPTH; i++) put(pat(100 + i), 1);
    settle();
    chk("R9 full flag", 64'(wflag), 64'd1);
    put(36'hBADBADBAD, 0);
    settle();
    chk("R9 still full", 64'(wflag), 64'd1);
    drain();
    chk("R9 full write ignored", 64'(exp_q.size()), 64'd0);
    chk("R9 empty after drain", 64'(rflag), 64'd1);

    for (int i = 0; i < 8; i++) put(pat(200 + i), 1);
    settle();
    chk("R4 aempty count=8", 64'(aempty), 64'd1);
    put(pat(208), 1);
    settle();
    chk("R4 aempty count=9", 64'(aempty), 64'd0);
    drain();

    // partial reset with preset 16, then retransmit
    mrst(0, 3'd1);
    for (int i = 0; i < 5; i++) put(pat(250 + i), 1);
    settle();
    @(posedge wclk); #2; part_rst_ni = 0;
    repeat (3) @(posedge wclk); #2;
    exp_q.delete();
    part_rst_ni = 1;
    settle();
    chk("R8 empty after partial reset", 64'(rflag), 64'd1);
    for (int i = 0; i < 16; i++) put(pat(300 + i), 1);
    settle();
    chk("R8 offset kept count=16", 64'(aempty), 64'd1);
    put(pat(316), 1);
    settle();
    chk("R8 offset kept count=17", 64'(aempty), 64'd0);
    drain();
    @(posedge rclk); #2; rt = 1;
    @(posedge rclk); #2; rt = 0;
    settle();
    chk("R10 data after rewind", 64'(rflag), 64'd0);
    for (int i = 0; i < 17; i++) exp_q.push_back(pat(300 + i));
    drain();
    chk("R10 replay complete", 64'(exp_q.size()), 64'd0);

    // fall-through timing, preset 64
    mrst(1, 3'd2);
    chk("R1 fwft rflag", 64'(rflag), 64'd0);
    chk("R1 fwft wflag", 64'(wflag), 64'd1);
    put(pat(500), 1);
    settle();
    chk("R3 output ready", 64'(rflag), 64'd1);
    chk("R3 word presented", 64'(rdata), 64'(pat(500)));
    for (int i = 1; i <= 64; i++) put(pat(500 + i), 1);
    settle();
    chk("R5 fwft held=64", 64'(aempty), 64'd1);
    put(pat(565), 1);
    settle();
    chk("R5 fwft held=65", 64'(aempty), 64'd0);
    drain();
    chk("R3 drained", 64'(exp_q.size()), 64'd0);
    chk("R3 not ready after drain", 64'(rflag), 64'd0);

    // serial offset load: empty 3, full 5
    mrst(0, 3'd5);
    put(36'hDEAD0DEAD, 0);
    shift_ofs(12'd3, 12'd5);
    for (int i = 0; i < 3; i++) put(pat(700 + i), 1);
    settle();
    chk("R6 aempty count=3", 64'(aempty), 64'd1);
    put(pat(703), 1);
    settle();
    chk("R6 aempty count=4", 64'(aempty), 64'd0);
    drain();
    chk("R6 early write ignored", 64'(exp_q.size()), 64'd0);

    // parallel offset load: empty 2, full 4
    mrst(0, 3'd6);
    put(36'd2, 0);
    put(36'd4, 0);
    for (int i = 0; i < DEPTH - 5; i++) put(pat(900 + i), 1);
    settle();
    chk("R7 afull free=5", 64'(afull), 64'd0);
    put(pat(900 + DEPTH - 5), 1);
    settle();
    chk("R7 afull free=4", 64'(afull), 64'd1);
    drain();
    chk("R7 offset words not stored", 64'(exp_q.size()), 64'd0);

    summary();
  end
endmodule